// File: doc/BRIEF.md
# Clock Gear with Lockup-Gated Multiplied Source

This block derives the system timing of a chip from one high-frequency source. The source is either the raw oscillator or a clock four times faster, produced by an on-chip frequency multiplier (PLL). Everything runs on one fast clock, `clk`, at the multiplied rate. The oscillator appears as a one-cycle qualifier, `osc_tick`, that is high on one `clk` cycle in every four. When the PLL is the source, every `clk` cycle counts as a source tick.

A programmable gear divides the source ticks by 1, 2, 4, 8 or 16 and produces `fph_en`, a one-cycle enable at the geared rate. A fixed halving stage after the gear produces `sys_en`, the enable for the system rate. Software writes two small registers. The first holds the gear code. The second holds a multiplier-enable bit and a source-select bit.

When the multiplier is enabled, a lockup counter starts counting oscillator ticks. Once it has counted `LOCK_TICKS` ticks it raises `lock_done`. Source changes must follow a fixed order. The multiplier is enabled first, and it may be selected only after lockup. To stop it, it is deselected first and disabled in a later write. A write that breaks this order has its offending bit ignored and raises `seq_err` for one cycle.

Top module: `clock_gear`

## Requirements
- R1: The gear register (cfg_addr=0, code in cfg_wdata[2:0]) sets the divide ratio: codes 0,1,2,3,4 give one `fph_en` pulse per 1,2,4,8,16 source ticks.
- R2: `sys_en` pulses on every second `fph_en` pulse and coincides with it, so its period is twice that of `fph_en`.
- R3: After reset the gear code reads 4, the multiplier is off, the oscillator is the source, `lock_done` and `seq_err` are 0, and `sys_en` runs at the oscillator rate divided by 32.
- R4: With the multiplier selected, every `clk` cycle is a source tick: gear code 2 gives an `fph_en` period of 4 cycles, and code 0 gives a period of 1 cycle.
- R5: After a write that turns the multiplier on, `lock_done` rises on the cycle after the LOCK_TICKS-th counted oscillator tick and not before.
- R6: A write to the PLL register (cfg_addr=1, bit1 = enable, bit0 = select) that enables and selects at once, while the multiplier is off, turns the multiplier on, leaves the source on the oscillator and pulses `seq_err`.
- R7: A write with select=1 while the multiplier is off or not locked leaves `pll_sel` at 0 and pulses `seq_err`.
- R8: A write with enable=0 while the multiplier is selected keeps `pll_on` at 1, applies its select bit, and pulses `seq_err`. This covers deselecting and disabling in one write.
- R9: Disabling the multiplier while the oscillator is the source clears `pll_on` and `lock_done` with no `seq_err`, and the oscillator then drives the gear again.
- R10: A new gear code takes effect only at the end of the current divided period. The interval that is running when the code is written keeps the old length.
- R11: Gear codes 5, 6 and 7 divide by 16, like code 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at the multiplied rate |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle qualifier marking each oscillator period |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = gear register, 1 = PLL register |
| cfg_wdata | input | 8 | Write data |
| gear_setting | output | 3 | Gear code most recently written |
| pll_on | output | 1 | Multiplier enabled |
| pll_sel | output | 1 | Multiplied clock is the source |
| lock_done | output | 1 | Lockup count complete |
| seq_err | output | 1 | One-cycle pulse after a write that broke the switch order |
| fph_en | output | 1 | Enable at the geared rate |
| sys_en | output | 1 | Enable at the system rate (half of `fph_en`) |

## Verification
The register outputs `pll_on`, `pll_sel`, `seq_err` and `gear_setting` change on the edge that captures the write. The bench therefore samples them at the falling edge right after that write. `fph_en` and `sys_en` are registered one cycle behind the source tick that ends a period. For this reason the bench measures them as distances between pulses, in cycles, and does not compare them to absolute times. It discards the first interval after a gear write, except in the R10 test, where that interval is the point of the check. `lock_done` is checked exactly 76 and 80 cycles after an enabling write, with LOCK_TICKS set to 20 and oscillator ticks every fourth cycle.

// File: rtl/clkgear_pkg.sv
package clkgear_pkg;
  localparam int unsigned GEAR_W    = 3;
  localparam int unsigned MAX_SHIFT = 4;
  localparam int unsigned CNT_W     = MAX_SHIFT;

  typedef enum logic {
    REG_GEAR = 1'b0,
    REG_PLL  = 1'b1
  } cfg_reg_e;

  // Number of doublings the gear code stands for; codes above the top clamp.
  function automatic int unsigned gear_shift(input logic [GEAR_W-1:0] code);
    return (int'(code) > int'(MAX_SHIFT)) ? MAX_SHIFT : int'(code);
  endfunction

  // Terminal count of the divider for a given gear code.
  function automatic logic [CNT_W-1:0] gear_last(input logic [GEAR_W-1:0] code);
    logic [CNT_W:0] span;
    span = (CNT_W+1)'(1) << gear_shift(code);
    return CNT_W'(span - (CNT_W+1)'(1));
  endfunction
endpackage

// File: rtl/clkgear_pll_ctrl.sv
module clkgear_pll_ctrl #(
  parameter int unsigned LOCK_TICKS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic wr_pll,
  input  logic on_req,
  input  logic sel_req,
  output logic pll_on,
  output logic pll_sel,
  output logic lock_done,
  output logic seq_err
);
  localparam int unsigned LCW = (LOCK_TICKS > 2) ? $clog2(LOCK_TICKS) : 1;
  localparam logic [LCW-1:0] LOCK_LAST = LCW'(LOCK_TICKS - 1);

  logic [LCW-1:0] lock_cnt;
  logic           sel_allowed;
  logic           next_sel;
  logic           next_on;
  logic           bad_select;
  logic           bad_disable;
  logic           turn_off;
  logic           count_tick;

  // Select is honoured only once the multiplier is on and locked.
  assign sel_allowed = pll_on && lock_done;
  assign next_sel    = sel_req && sel_allowed;
  // The multiplier cannot be stopped while it is still the source.
  assign next_on     = on_req || pll_sel;
  assign bad_select  = sel_req && !sel_allowed;
  assign bad_disable = !on_req && pll_sel;
  assign turn_off    = wr_pll && !next_on;
  assign count_tick  = pll_on && !lock_done && osc_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pll_on  <= 1'b0;
      pll_sel <= 1'b0;
      seq_err <= 1'b0;
    end else if (wr_pll) begin
      pll_on  <= next_on;
      pll_sel <= next_sel;
      seq_err <= bad_select || bad_disable;
    end else begin
      seq_err <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || turn_off) begin
      lock_cnt  <= '0;
      lock_done <= 1'b0;
    end else if (count_tick) begin
      if (lock_cnt == LOCK_LAST) lock_done <= 1'b1;
      else                       lock_cnt  <= lock_cnt + LCW'(1);
    end
  end

  assert_sel_needs_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pll_sel |-> lock_done);
  assert_sel_keeps_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pll_sel |-> pll_on);
  assert_lock_drops_with_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_on |-> !lock_done);
  assert_lock_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_done) |-> ($past(osc_tick) && pll_on));
endmodule

// File: rtl/clkgear_div.sv
module clkgear_div
  import clkgear_pkg::*;
#(
  parameter logic [GEAR_W-1:0] RST_GEAR = 3'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_tick,
  input  logic [GEAR_W-1:0] gear_req,
  output logic              fph_en,
  output logic              sys_en
);
  logic [GEAR_W-1:0] gear_act;
  logic [CNT_W-1:0]  div_cnt;
  logic              half_phase;
  logic              at_boundary;

  assign at_boundary = src_tick && (div_cnt == gear_last(gear_act));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gear_act   <= RST_GEAR;
      div_cnt    <= '0;
      half_phase <= 1'b0;
      fph_en     <= 1'b0;
      sys_en     <= 1'b0;
    end else if (at_boundary) begin
      gear_act   <= gear_req;
      div_cnt    <= '0;
      half_phase <= !half_phase;
      fph_en     <= 1'b1;
      sys_en     <= half_phase;
    end else begin
      if (src_tick) div_cnt <= div_cnt + CNT_W'(1);
      fph_en <= 1'b0;
      sys_en <= 1'b0;
    end
  end

  assert_sys_on_gear_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sys_en |-> fph_en);
  assert_gear_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gear_act != $past(gear_act)) |-> $past(at_boundary));
endmodule

// File: rtl/clock_gear.sv
module clock_gear
  import clkgear_pkg::*;
#(
  parameter int unsigned       LOCK_TICKS = 4096,
  parameter int unsigned       DW         = 8,
  parameter logic [GEAR_W-1:0] RST_GEAR   = 3'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              cfg_wr,
  input  logic              cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [GEAR_W-1:0] gear_setting,
  output logic              pll_on,
  output logic              pll_sel,
  output logic              lock_done,
  output logic              seq_err,
  output logic              fph_en,
  output logic              sys_en
);
  localparam int unsigned SEL_BIT = 0;
  localparam int unsigned ON_BIT  = 1;

  logic [GEAR_W-1:0] gear_q;
  logic              wr_gear;
  logic              wr_pll;
  logic              src_tick;

  assign wr_gear  = cfg_wr && (cfg_reg_e'(cfg_addr) == REG_GEAR);
  assign wr_pll   = cfg_wr && (cfg_reg_e'(cfg_addr) == REG_PLL);
  // Multiplied clock ticks every cycle; the oscillator only on its qualifier.
  assign src_tick = pll_sel ? 1'b1 : osc_tick;

  always_ff @(posedge clk) begin
    if (!rst_n)       gear_q <= RST_GEAR;
    else if (wr_gear) gear_q <= cfg_wdata[GEAR_W-1:0];
  end
  assign gear_setting = gear_q;

  clkgear_pll_ctrl #(.LOCK_TICKS(LOCK_TICKS)) u_pll (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_tick  (osc_tick),
    .wr_pll    (wr_pll),
    .on_req    (cfg_wdata[ON_BIT]),
    .sel_req   (cfg_wdata[SEL_BIT]),
    .pll_on    (pll_on),
    .pll_sel   (pll_sel),
    .lock_done (lock_done),
    .seq_err   (seq_err)
  );

  clkgear_div #(.RST_GEAR(RST_GEAR)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_tick (src_tick),
    .gear_req (gear_q),
    .fph_en   (fph_en),
    .sys_en   (sys_en)
  );

  assert_err_only_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> $past(wr_pll));
endmodule

// File: tb/sim_clock_gear.sv
`timescale 1ns/1ps
module sim_clock_gear;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic       cfg_wr = 1'b0;
  logic       cfg_addr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [2:0] gear_setting;
  logic       pll_on, pll_sel, lock_done, seq_err, fph_en, sys_en;

  int n_checks = 0;
  int n_fail = 0;

  // {gear code, expected fph period in clk cycles on the oscillator (tick every 4)}
  localparam int VEC [8][2] = '{
    '{0, 4}, '{1, 8}, '{2, 16}, '{3, 32},
    '{4, 64}, '{5, 64}, '{6, 64}, '{7, 64}
  };

  always #2.5 clk = ~clk;

  clock_gear #(.LOCK_TICKS(20)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .gear_setting(gear_setting),
    .pll_on(pll_on), .pll_sel(pll_sel), .lock_done(lock_done),
    .seq_err(seq_err), .fph_en(fph_en), .sys_en(sys_en)
  );

  initial begin
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 4;
      osc_tick = (ph == 0);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic a, input logic [7:0] d);
    cfg_addr  = a;
    cfg_wdata = d;
    cfg_wr    = 1'b1;
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  task automatic measure(input bit use_sys, output int p);
    forever begin
      @(negedge clk);
      if (use_sys ? sys_en : fph_en) break;
    end
    p = 0;
    forever begin
      @(negedge clk);
      p++;
      if (use_sys ? sys_en : fph_en) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int p;
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R3: reset state
    check("R3 gear", int'(gear_setting), 4);
    check("R3 pll_on", int'(pll_on), 0);
    check("R3 pll_sel", int'(pll_sel), 0);
    check("R3 lock", int'(lock_done), 0);
    check("R3 err", int'(seq_err), 0);
    measure(1'b0, p); check("R3 fph period", p, 64);
    measure(1'b1, p); check("R3 sys period", p, 128);

    // R1 / R2 / R11: table of gear codes on the oscillator source
    for (int i = 0; i < 8; i++) begin
      do_write(1'b0, 8'(VEC[i][0]));
      check("R1 gear readback", int'(gear_setting), VEC[i][0]);
      measure(1'b0, p);
      measure(1'b0, p);
      check(i > 4 ? "R11 fph period" : "R1 fph period", p, VEC[i][1]);
      measure(1'b1, p);
      measure(1'b1, p);
      check("R2 sys period", p, 2 * VEC[i][1]);
    end

    // R10: gear change lands only at the boundary
    do_write(1'b0, 8'd4);
    measure(1'b0, p);
    measure(1'b0, p);
    forever begin
      @(negedge clk);
      if (fph_en) break;
    end
    do_write(1'b0, 8'd0);
    n = 1;
    while (!fph_en) begin
      @(negedge clk);
      n++;
    end
    check("R10 running interval", n, 64);
    measure(1'b0, p);
    check("R10 new interval", p, 4);

    // R7: select while off is ignored
    do_write(1'b1, 8'b01);
    check("R7 sel", int'(pll_sel), 0);
    check("R7 on", int'(pll_on), 0);
    check("R7 err", int'(seq_err), 1);

    // R6: enable and select in one write
    do_write(1'b1, 8'b11);
    check("R6 on", int'(pll_on), 1);
    check("R6 sel", int'(pll_sel), 0);
    check("R6 err", int'(seq_err), 1);

    // R5 / R7: lockup timing, with a premature select in the middle
    repeat (10) @(negedge clk);
    do_write(1'b1, 8'b11);
    check("R7 sel before lock", int'(pll_sel), 0);
    check("R7 err before lock", int'(seq_err), 1);
    repeat (65) @(negedge clk);
    check("R5 lock not yet", int'(lock_done), 0);
    repeat (4) @(negedge clk);
    check("R5 lock done", int'(lock_done), 1);

    // R4: select multiplied source
    do_write(1'b1, 8'b11);
    check("R4 sel", int'(pll_sel), 1);
    check("R4 err", int'(seq_err), 0);
    do_write(1'b0, 8'd2);
    measure(1'b0, p);
    measure(1'b0, p);
    check("R4 fph gear2", p, 4);
    measure(1'b1, p);
    check("R4 sys gear2", p, 8);
    do_write(1'b0, 8'd0);
    measure(1'b0, p);
    measure(1'b0, p);
    check("R4 fph gear0", p, 1);
    measure(1'b1, p);
    check("R4 sys gear0", p, 2);

    // R8: deselect and disable in one write
    do_write(1'b1, 8'b00);
    check("R8 sel", int'(pll_sel), 0);
    check("R8 on kept", int'(pll_on), 1);
    check("R8 lock kept", int'(lock_done), 1);
    check("R8 err", int'(seq_err), 1);

    // R9: legal disable
    do_write(1'b1, 8'b00);
    check("R9 on", int'(pll_on), 0);
    check("R9 lock", int'(lock_done), 0);
    check("R9 err", int'(seq_err), 0);
    measure(1'b0, p);
    measure(1'b0, p);
    check("R9 osc fph", p, 4);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule